// File: doc/BRIEF.md
# Multi-Channel Countdown Timer with Register Port

This block is a memory-mapped timer peripheral with a parameterised number of independent down-counting channels. Software programs each channel through a simple synchronous read/write port. A channel has a 64-bit interval, a control byte (run enable, reload request, clock prescale select and one-shot/periodic choice) and a readable 64-bit current count. Two shared registers, one interrupt-enable and one interrupt-status, each hold one bit per channel. A single interrupt line is raised while any channel has both its status bit and its enable bit set.

The counters live in a separate timer clock domain. Configuration written on the register side is handed across as one whole set through a toggle request/acknowledge handshake. The current count comes back as a snapshot through a second handshake, and expiries return as toggles. A control change therefore reaches its counter a few timer-clock cycles after the write. A cleared enable likewise stops the counter only after that short delay.

Typical uses are a periodic tick (periodic mode with a fixed interval) and a next-event timer (one-shot mode). A channel with an all-ones interval in periodic mode also serves as a free-running time base: reading its count and inverting it gives an up-count.

Top module: `mmio_countdown_timer`

## Requirements
- R1: After reset every register reads 0, the interrupt output is low and no counter runs.
- R2: Register map (byte addresses, 32-bit data, read data valid the cycle after the request): interrupt enable at 0x00 and interrupt status at 0x04, with bit n for channel n. For channel n, relative to 0x20*n: control at 0x10, interval low/high at 0x14/0x18, count low/high at 0x1C/0x20. The interval reads back as written.
- R3: Control byte: bit 0 run enable, bit 1 reload request, bits 6:4 prescale select, bit 7 one-shot (0 = periodic). Bits 3:2 and 31:8 read as 0.
- R4: Writing control with bit 1 set loads the interval into the counter in the timer domain. Bit 1 reads 1 until that load is delivered, then reads 0.
- R5: A running counter decrements once every 2^sel timer-clock cycles. Without a reload, successive count reads never increase.
- R6: In periodic mode, a tick at count 0 sets the channel's status bit and reloads the interval, so expiries repeat every (interval+1) ticks.
- R7: In one-shot mode, a tick at count 0 sets the status bit once and the counter stays at 0 until the next reload.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Writes to the count registers have no effect.
- R9: Status bits set whether or not interrupts are enabled. The interrupt output is high exactly when some channel has both status and enable set.
- R10: After the enable bit is cleared, the counter stops within a few timer-clock cycles and holds its value.
- R11: Writes made while an earlier transfer is still in flight are merged, and the latest values are delivered once the handshake completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-port clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| tclk | input | 1 | Timer counting clock |
| req | input | 1 | Register access strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after a read request |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong divider or decrement shows at the ports as a count difference between two reads that is off from the expected tick count by far more than the handshake staleness of a few ticks. A reload or expiry fault shows within one interval as a missing, doubled or stuck status bit, or as a counter that is not at 0 after a one-shot expiry. A broken domain handshake shows within tens of cycles as a reload bit that never clears, a wrong count after a reload, or a counter that keeps moving after it has been disabled.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int TMR_DW    = 32;
    localparam int TMR_CNT_W = 64;
    localparam int TMR_PRE_W = 3;

    localparam int TMR_OFS_IEN    = 'h00;
    localparam int TMR_OFS_IST    = 'h04;
    localparam int TMR_CH_STRIDE  = 'h20;
    localparam int TMR_OFS_CTL    = 'h10;
    localparam int TMR_OFS_ILO    = 'h14;
    localparam int TMR_OFS_IHI    = 'h18;
    localparam int TMR_OFS_CLO    = 'h1C;
    localparam int TMR_OFS_CHI    = 'h20;

    typedef struct packed {
        logic                 oneshot;
        logic [TMR_PRE_W-1:0] presc;
        logic                 reload;
        logic                 en;
    } ctl_t;

    function automatic ctl_t ctl_unpack(input logic [7:0] w);
        ctl_t c;
        c.en      = w[0];
        c.reload  = w[1];
        c.presc   = w[6:4];
        c.oneshot = w[7];
        return c;
    endfunction

    function automatic logic [7:0] ctl_pack(input ctl_t c);
        return {c.oneshot, c.presc, 2'b00, c.reload, c.en};
    endfunction
endpackage

// File: rtl/tmr_sync2.sv
module tmr_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/tmr_chan_core.sv
module tmr_chan_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = TMR_CNT_W
) (
    input  logic             tclk,
    input  logic             rst_n,
    input  logic             cfg_req,
    input  ctl_t             cfg_ctl,
    input  logic [CNT_W-1:0] cfg_ival,
    input  logic             snap_req,
    output logic             cfg_ack,
    output logic             snap_ack,
    output logic [CNT_W-1:0] snap_cnt,
    output logic             exp_tgl
);
    localparam int DIV_W = (1 << TMR_PRE_W) - 1;

    typedef struct packed {
        logic                 en;
        logic                 oneshot;
        logic [TMR_PRE_W-1:0] presc;
        logic                 stopped;
        logic [CNT_W-1:0]     ival;
        logic [CNT_W-1:0]     cnt;
        logic [DIV_W-1:0]     pdiv;
        logic                 cfg_ack;
        logic                 snap_ack;
        logic [CNT_W-1:0]     snap;
        logic                 exp_tgl;
    } st_t;

    st_t q, d;
    logic [1:0] req_raw, req_s;
    logic cfg_new, snap_new, run, tick;
    logic [DIV_W-1:0] div_lim;

    assign req_raw = {cfg_req, snap_req};

    tmr_sync2 #(.W(2)) u_req_sync (
        .clk  (tclk),
        .rst_n(rst_n),
        .d    (req_raw),
        .q    (req_s)
    );

    always_comb begin
        d        = q;
        cfg_new  = req_s[1] != q.cfg_ack;
        snap_new = req_s[0] != q.snap_ack;
        run      = q.en & ~q.stopped;
        tick     = 1'b0;
        div_lim  = DIV_W'((32'd1 << q.presc) - 32'd1);

        if (run) begin
            if (q.pdiv == div_lim) begin
                d.pdiv = '0;
                tick   = 1'b1;
            end else begin
                d.pdiv = q.pdiv + 1'b1;
            end
        end else begin
            d.pdiv = '0;
        end

        if (tick) begin
            if (q.cnt == '0) begin
                d.exp_tgl = ~q.exp_tgl;
                if (q.oneshot) d.stopped = 1'b1;
                else           d.cnt     = q.ival;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end

        if (cfg_new) begin
            d.cfg_ack = ~q.cfg_ack;
            d.en      = cfg_ctl.en;
            d.oneshot = cfg_ctl.oneshot;
            d.presc   = cfg_ctl.presc;
            d.ival    = cfg_ival;
            if (cfg_ctl.reload) begin
                d.cnt     = cfg_ival;
                d.pdiv    = '0;
                d.stopped = 1'b0;
            end
        end

        if (snap_new) begin
            d.snap     = q.cnt;
            d.snap_ack = ~q.snap_ack;
        end
    end

    always_ff @(posedge tclk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cfg_ack  = q.cfg_ack;
    assign snap_ack = q.snap_ack;
    assign snap_cnt = q.snap;
    assign exp_tgl  = q.exp_tgl;

    // R5
    dec_step_chk: assert property (@(posedge tclk) disable iff (!rst_n)
        (tick && q.cnt != '0 && !cfg_new) |=> (q.cnt == $past(q.cnt) - 1'b1));

    // R6
    periodic_reload_chk: assert property (@(posedge tclk) disable iff (!rst_n)
        (tick && q.cnt == '0 && !q.oneshot && !cfg_new) |=> (q.cnt == $past(q.ival)));

    // R7
    oneshot_stop_chk: assert property (@(posedge tclk) disable iff (!rst_n)
        (tick && q.cnt == '0 && q.oneshot && !cfg_new) |=> (q.stopped && q.cnt == '0));

    // R10
    idle_hold_chk: assert property (@(posedge tclk) disable iff (!rst_n)
        (!run && !cfg_new) |=> $stable(q.cnt));
endmodule

// File: rtl/tmr_chan_bridge.sv
module tmr_chan_bridge
    import tmr_pkg::*;
#(
    parameter int CNT_W = TMR_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic              wr_ilo,
    input  logic              wr_ihi,
    input  logic [TMR_DW-1:0] wdata,
    input  logic              cfg_ack,
    input  logic              snap_ack,
    input  logic [CNT_W-1:0]  snap_cnt,
    input  logic              exp_tgl,
    output logic [7:0]        ctl_rd,
    output logic [CNT_W-1:0]  ival_rd,
    output logic [CNT_W-1:0]  cnt_rd,
    output logic              exp_pulse,
    output logic              cfg_req,
    output ctl_t              l_ctl,
    output logic [CNT_W-1:0]  l_ival,
    output logic              snap_req
);
    typedef struct packed {
        ctl_t             ctl;
        logic [CNT_W-1:0] ival;
        logic             dirty;
        ctl_t             l_ctl;
        logic [CNT_W-1:0] l_ival;
        logic             cfg_req;
        logic             snap_req;
        logic [CNT_W-1:0] cnt;
        logic             exp_seen;
    } st_t;

    st_t q, d;
    logic [2:0] ack_raw, ack_s;
    logic busy;
    ctl_t shown;

    assign ack_raw = {cfg_ack, snap_ack, exp_tgl};

    tmr_sync2 #(.W(3)) u_ack_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (ack_raw),
        .q    (ack_s)
    );

    always_comb begin
        d         = q;
        busy      = q.cfg_req != ack_s[2];
        exp_pulse = ack_s[0] != q.exp_seen;
        d.exp_seen = ack_s[0];

        if (!busy && q.dirty) begin
            d.l_ctl      = q.ctl;
            d.l_ival     = q.ival;
            d.cfg_req    = ~q.cfg_req;
            d.dirty      = 1'b0;
            d.ctl.reload = 1'b0;
        end

        if (q.snap_req == ack_s[1]) begin
            d.cnt      = snap_cnt;
            d.snap_req = ~q.snap_req;
        end

        if (wr_ctl) begin
            d.ctl   = ctl_unpack(wdata[7:0]);
            d.dirty = 1'b1;
        end
        if (wr_ilo) begin
            d.ival[TMR_DW-1:0] = wdata;
            d.dirty            = 1'b1;
        end
        if (wr_ihi) begin
            d.ival[CNT_W-1:TMR_DW] = wdata[CNT_W-TMR_DW-1:0];
            d.dirty                = 1'b1;
        end

        shown        = q.ctl;
        shown.reload = q.ctl.reload | (busy & q.l_ctl.reload);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctl_rd   = ctl_pack(shown);
    assign ival_rd  = q.ival;
    assign cnt_rd   = q.cnt;
    assign cfg_req  = q.cfg_req;
    assign l_ctl    = q.l_ctl;
    assign l_ival   = q.l_ival;
    assign snap_req = q.snap_req;

    // R11
    launch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(q.l_ival) && $stable(q.l_ctl)));

    // R4
    reload_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && q.dirty && !wr_ctl) |=> !q.ctl.reload);
endmodule

// File: rtl/mmio_countdown_timer.sv
module mmio_countdown_timer
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tclk,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TMR_DW-1:0] wdata,
    output logic [TMR_DW-1:0] rdata,
    output logic              irq
);
    localparam int CW = TMR_CNT_W;

    typedef struct packed {
        logic [NUM_CH-1:0] ien;
        logic [NUM_CH-1:0] ist;
        logic [TMR_DW-1:0] rdata;
    } st_t;

    st_t q, d;

    logic [NUM_CH-1:0] hit_ctl, hit_ilo, hit_ihi, hit_clo, hit_chi;
    logic [NUM_CH-1:0] wr_ctl, wr_ilo, wr_ihi, exp_pulse;
    logic [NUM_CH-1:0] cfg_req, cfg_ack, snap_req, snap_ack, exp_tgl;
    logic [7:0]    ctl_rd   [NUM_CH];
    logic [CW-1:0] ival_rd  [NUM_CH];
    logic [CW-1:0] cnt_rd   [NUM_CH];
    logic [CW-1:0] l_ival   [NUM_CH];
    logic [CW-1:0] snap_cnt [NUM_CH];
    ctl_t          l_ctl    [NUM_CH];

    logic hit_ien, hit_ist, wr_ist;
    logic [NUM_CH-1:0] clr_mask;
    logic [TMR_DW-1:0] rd_val;

    assign hit_ien = addr == ADDR_W'(TMR_OFS_IEN);
    assign hit_ist = addr == ADDR_W'(TMR_OFS_IST);
    assign wr_ist  = req & we & hit_ist;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(TMR_CH_STRIDE * g);

        assign hit_ctl[g] = addr == BASE + ADDR_W'(TMR_OFS_CTL);
        assign hit_ilo[g] = addr == BASE + ADDR_W'(TMR_OFS_ILO);
        assign hit_ihi[g] = addr == BASE + ADDR_W'(TMR_OFS_IHI);
        assign hit_clo[g] = addr == BASE + ADDR_W'(TMR_OFS_CLO);
        assign hit_chi[g] = addr == BASE + ADDR_W'(TMR_OFS_CHI);
        assign wr_ctl[g]  = req & we & hit_ctl[g];
        assign wr_ilo[g]  = req & we & hit_ilo[g];
        assign wr_ihi[g]  = req & we & hit_ihi[g];

        tmr_chan_bridge #(.CNT_W(CW)) u_bridge (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_ctl   (wr_ctl[g]),
            .wr_ilo   (wr_ilo[g]),
            .wr_ihi   (wr_ihi[g]),
            .wdata    (wdata),
            .cfg_ack  (cfg_ack[g]),
            .snap_ack (snap_ack[g]),
            .snap_cnt (snap_cnt[g]),
            .exp_tgl  (exp_tgl[g]),
            .ctl_rd   (ctl_rd[g]),
            .ival_rd  (ival_rd[g]),
            .cnt_rd   (cnt_rd[g]),
            .exp_pulse(exp_pulse[g]),
            .cfg_req  (cfg_req[g]),
            .l_ctl    (l_ctl[g]),
            .l_ival   (l_ival[g]),
            .snap_req (snap_req[g])
        );

        tmr_chan_core #(.CNT_W(CW)) u_core (
            .tclk    (tclk),
            .rst_n   (rst_n),
            .cfg_req (cfg_req[g]),
            .cfg_ctl (l_ctl[g]),
            .cfg_ival(l_ival[g]),
            .snap_req(snap_req[g]),
            .cfg_ack (cfg_ack[g]),
            .snap_ack(snap_ack[g]),
            .snap_cnt(snap_cnt[g]),
            .exp_tgl (exp_tgl[g])
        );

        // R8
        w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_ist && wdata[g] && !exp_pulse[g]) |=> !q.ist[g]);

        // R9
        status_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(q.ist[g]) |-> $past(exp_pulse[g]));
    end

    always_comb begin
        d        = q;
        clr_mask = wr_ist ? wdata[NUM_CH-1:0] : '0;
        d.ist    = (q.ist & ~clr_mask) | exp_pulse;
        if (req && we && hit_ien) d.ien = wdata[NUM_CH-1:0];

        rd_val = '0;
        if (hit_ien) rd_val[NUM_CH-1:0] = q.ien;
        if (hit_ist) rd_val[NUM_CH-1:0] = q.ist;
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit_ctl[i]) rd_val = TMR_DW'(ctl_rd[i]);
            if (hit_ilo[i]) rd_val = ival_rd[i][TMR_DW-1:0];
            if (hit_ihi[i]) rd_val = ival_rd[i][CW-1:TMR_DW];
            if (hit_clo[i]) rd_val = cnt_rd[i][TMR_DW-1:0];
            if (hit_chi[i]) rd_val = cnt_rd[i][CW-1:TMR_DW];
        end
        if (req && !we) d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata = q.rdata;
    assign irq   = |(q.ist & q.ien);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq && q.ist == '0));
endmodule

// File: tb/mmio_countdown_timer_bench.sv
module mmio_countdown_timer_bench;
    logic clk = 1'b0, tclk = 1'b0, rst_n = 1'b0;
    logic req = 1'b0, we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic irq;
    int n_chk = 0, n_err = 0;
    int unsigned cyc = 0;

    always #10 clk  = ~clk;
    always #8  tclk = ~tclk;
    always @(posedge clk) cyc <= cyc + 1;

    mmio_countdown_timer u_mmio_countdown_timer (
        .clk(clk), .rst_n(rst_n), .tclk(tclk), .req(req), .we(we),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic logic [7:0] a_ctl(input int ch); return 8'(8'h10 + 32 * ch); endfunction
    function automatic logic [7:0] a_ilo(input int ch); return 8'(8'h14 + 32 * ch); endfunction
    function automatic logic [7:0] a_ihi(input int ch); return 8'(8'h18 + 32 * ch); endfunction
    function automatic logic [7:0] a_clo(input int ch); return 8'(8'h1C + 32 * ch); endfunction
    function automatic logic [7:0] a_chi(input int ch); return 8'(8'h20 + 32 * ch); endfunction

    function automatic logic [31:0] ctl_w(input bit en, input bit rl, input int sel, input bit os);
        return {24'b0, os, 3'(sel), 2'b00, rl, en};
    endfunction

    // expected ticks for a number of bus cycles (20 ns) at 16 ns timer clock
    function automatic longint exp_ticks(input longint cycles, input int sel);
        return (cycles * 20) / (longint'(16) << sel);
    endfunction

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = v;
        @(negedge clk); req = 1'b0; we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk); req = 1'b0; v = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string r, input longint act, input longint expv);
        n_chk++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", r, act, expv);
        end
    endtask

    task automatic chk_rng(input string r, input longint act, input longint lo, input longint hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_err++;
            $display("FAIL %s act=%0d exp=%0d..%0d", r, act, lo, hi);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] v, v2, lo, hi, c0, c1, c2;
        int unsigned t0;
        int events;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        idle(5);

        // R1: reset state
        chk("R1 irq", longint'(irq), 0);
        bus_rd(8'h00, v); chk("R1 ien", v, 0);
        bus_rd(8'h04, v); chk("R1 ist", v, 0);
        for (int ch = 0; ch < 2; ch++) begin
            bus_rd(a_ctl(ch), v); chk("R1 ctl", v, 0);
            bus_rd(a_ilo(ch), v); chk("R1 ilo", v, 0);
            bus_rd(a_ihi(ch), v); chk("R1 ihi", v, 0);
            bus_rd(a_clo(ch), v); chk("R1 clo", v, 0);
            bus_rd(a_chi(ch), v); chk("R1 chi", v, 0);
        end

        // R2 R3: random readback of interval and control fields
        for (int k = 0; k < 20; k++) begin
            int ch;
            ch = int'($urandom % 2);
            lo = $urandom; hi = $urandom; v2 = $urandom & 32'hFFFF_FFFC;
            bus_wr(a_ilo(ch), lo);
            bus_wr(a_ihi(ch), hi);
            bus_wr(a_ctl(ch), v2);
            bus_rd(a_ilo(ch), v); chk("R2 interval low", v, lo);
            bus_rd(a_ihi(ch), v); chk("R2 interval high", v, hi);
            bus_rd(a_ctl(ch), v); chk("R3 control fields", v, v2 & 32'hF0);
        end
        bus_wr(a_ctl(0), 0); bus_wr(a_ctl(1), 0);
        idle(40);

        // R4: reload loads interval, bit 1 self-clears
        bus_wr(a_ilo(0), 32'd1234);
        bus_wr(a_ihi(0), 32'd5);
        bus_wr(a_ctl(0), ctl_w(0, 1, 0, 0));
        bus_rd(a_ctl(0), v); chk("R4 reload pending", v, 32'h02);
        idle(40);
        bus_rd(a_ctl(0), v); chk("R4 reload cleared", v, 32'h00);
        bus_rd(a_clo(0), v); chk("R4 count low loaded", v, 1234);
        bus_rd(a_chi(0), v); chk("R4 count high loaded", v, 5);

        // R8: count registers ignore writes
        bus_wr(a_clo(0), 32'hFFFF);
        bus_wr(a_chi(0), 32'h77);
        idle(40);
        bus_rd(a_clo(0), v); chk("R8 count low write ignored", v, 1234);
        bus_rd(a_chi(0), v); chk("R8 count high write ignored", v, 5);

        // R5: decrement rate for several prescale selects
        bus_wr(a_ihi(0), 0);
        for (int s = 0; s < 3; s++) begin
            int sel;
            sel = (s == 0) ? 0 : (s == 1) ? 3 : int'($urandom % 8);
            bus_wr(a_ilo(0), 32'h00FF_FFFF);
            bus_wr(a_ctl(0), ctl_w(1, 1, sel, 0));
            idle(40);
            bus_rd(a_clo(0), c1);
            idle(798);
            bus_rd(a_clo(0), c2);
            n_chk++;
            if (c2 > c1) begin
                n_err++;
                $display("FAIL R5 count increased act=%0d exp<=%0d", c2, c1);
            end
            chk_rng("R5 tick rate", longint'(c1 - c2),
                    exp_ticks(800, sel) - 10, exp_ticks(800, sel) + 10);
        end

        // R10: disable stops counter and holds it
        bus_wr(a_ctl(0), ctl_w(1, 1, 0, 0));
        idle(40);
        bus_rd(a_clo(0), c0);
        bus_wr(a_ctl(0), ctl_w(0, 0, 0, 0));
        idle(30);
        bus_rd(a_clo(0), c1);
        idle(200);
        bus_rd(a_clo(0), c2);
        chk("R10 count held after disable", c2, c1);
        chk_rng("R10 stop latency", longint'(c0 - c1), 0, 30);

        // R6: periodic expiry rate, interval 20 -> 21 ticks per expiry
        bus_wr(a_ilo(0), 32'd20);
        bus_wr(a_ctl(0), ctl_w(1, 1, 0, 0));
        idle(40);
        bus_wr(8'h04, 32'h3);
        events = 0;
        t0 = cyc;
        while (cyc - t0 < 1680) begin
            bus_rd(8'h04, v);
            if (v[0]) begin
                events++;
                bus_wr(8'h04, 32'h1);
            end
        end
        chk_rng("R6 periodic expiry count", longint'(events), 98, 102);

        // R9: irq follows status and enable
        bus_wr(8'h00, 32'h1);
        v = 0;
        for (int k = 0; k < 40 && !v[0]; k++) bus_rd(8'h04, v);
        chk("R9 irq with status and enable", longint'(irq), 1);
        bus_wr(a_ctl(0), 0);
        bus_wr(8'h00, 32'h0);
        chk("R9 irq off when disabled", longint'(irq), 0);
        bus_rd(8'h04, v); chk("R9 status set without enable", v[0], 1);
        idle(40);
        bus_wr(8'h04, 32'h1);
        bus_rd(8'h04, v); chk("R8 status cleared by one", v, 0);

        // R7: one-shot on channel 1
        bus_wr(a_ilo(1), 32'd10);
        bus_wr(a_ihi(1), 32'd0);
        bus_wr(a_ctl(1), ctl_w(1, 1, 0, 1));
        idle(100);
        bus_rd(8'h04, v); chk("R7 one-shot status", v, 32'h2);
        bus_rd(a_clo(1), v); chk("R7 one-shot count at zero", v, 0);
        bus_wr(8'h04, 32'h0);
        bus_rd(8'h04, v); chk("R8 writing zero keeps status", v, 32'h2);
        bus_wr(8'h04, 32'h2);
        idle(200);
        bus_rd(8'h04, v); chk("R7 one-shot fires once", v, 0);
        bus_rd(a_clo(1), v); chk("R7 one-shot stays at zero", v, 0);

        // R11: back-to-back writes merged, latest wins
        bus_wr(a_ctl(1), 0);
        bus_wr(a_ilo(1), 32'd111);
        bus_wr(a_ilo(1), 32'd222);
        bus_wr(a_ctl(1), ctl_w(0, 1, 0, 0));
        idle(40);
        bus_rd(a_clo(1), v); chk("R11 latest interval delivered", v, 222);
        bus_rd(a_ctl(1), v); chk("R11 control after merge", v, 0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule